// File: doc/BRIEF.md
# Cascadable Serial Wiper-Register Port

This block is a three-wire synchronous serial port that fronts a bank of wiper-position registers (four of them by default, eight bits each). The host raises an enable input to open a session. A read/write select chooses the direction, a serial clock times each bit, a serial data input carries the bits in, and a cascade output carries bits out. In write sessions a stream is clocked into a shift chain, and the stored registers take the new values when the session closes. In read sessions the stored values are clocked out one bit per serial clock. While the port is disabled the cascade output simply repeats the data input, so several ports can be chained on one data line.

All serial inputs are sampled by the block's system clock. The serial clock edges and the enable edges are detected from those samples, so each serial clock phase must last at least two system clock cycles. The register bank is exported in parallel for the analog side to use.

Top module: `wiper_serial_port`

## Requirements
- R1: After a synchronous reset (`rst` high) every wiper register reads zero. Wiper k appears on `wiper_pos[k*WIPER_W +: WIPER_W]`.
- R2: While `port_en` is low, `cascade_out` equals `sdin` in the same time step, with no clock involved.
- R3: While `port_en` is high and `rd_wr_n` is low (write session), `cascade_out` is held at 0.
- R4: In a write session `sdin` is captured at each rising edge of `sclk`. When `port_en` falls after at least 32 captured bits, the last 32 bits are loaded within two system clock cycles. The earliest of those bits goes to wiper 0's MSB, then the bits run on in order to wiper 3's LSB.
- R5: When more than 32 bits are shifted in a write session, only the final 32 bits reach the registers.
- R6: When fewer than 32 bits are shifted before `port_en` falls, all wiper registers keep their previous values.
- R7: In a read session (`rd_wr_n` high) each falling edge of `sclk` presents the next stored bit on `cascade_out` within two system clock cycles. The bits come out as wiper 0 MSB first through its LSB, then wiper 1, then wiper 2, then wiper 3.
- R8: Each new enable restarts readback at wiper 0's MSB. `cascade_out` is 0 in a read session until the first falling `sclk` edge.
- R9: After all 32 stored bits have been read, further falling `sclk` edges in the same session present 0.
- R10: The wiper registers never change while the port is enabled, and a read session leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Session enable. High opens the port and the falling edge commits writes |
| rd_wr_n | input | 1 | Direction: 1 = read, 0 = write |
| sclk | input | 1 | Serial bit clock |
| sdin | input | 1 | Serial data input |
| cascade_out | output | 1 | Serial/cascade output |
| wiper_pos | output | WIPER_W*NUM_WIPERS | Parallel wiper registers, wiper k at bits k*WIPER_W upward |

## Verification
The bench goes after frame-length edges. If the bit counter is off by one, a frame of exactly 32 bits is dropped or a 31-bit frame is committed. If bits are taken from the wrong end of the chain, an over-long frame lands shifted. It checks the order of readback bits, since a reversed bit or register order shows up as mismatches on every word that is not a palindrome. It also reads part of a frame, re-enables the port, and reads past the end of the frame, which exposes a read pointer that does not restart or that wraps around. Pass-through and inhibit are checked at the output pin, together with the reset state.

// File: rtl/wiper_port_pkg.sv
package wiper_port_pkg;

    localparam int unsigned DEF_WIPER_W    = 8;
    localparam int unsigned DEF_NUM_WIPERS = 4;

    // registered copies of the serial pins
    typedef struct packed {
        logic en;
        logic rd;
        logic sclk;
        logic din;
    } port_sample_t;

    // single-cycle events derived from the samples
    typedef struct packed {
        logic en_rise;
        logic en_fall;
        logic sclk_rise;
        logic sclk_fall;
    } port_event_t;

    function automatic int unsigned frame_len(input int unsigned w, input int unsigned n);
        return w * n;
    endfunction

endpackage

// File: rtl/wport_sampler.sv
module wport_sampler
    import wiper_port_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         port_en,
    input  logic         rd_wr_n,
    input  logic         sclk,
    input  logic         sdin,
    output port_sample_t smp,
    output port_event_t  ev
);
    logic en_prev;
    logic sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp       <= '0;
            en_prev   <= 1'b0;
            sclk_prev <= 1'b0;
        end else begin
            smp       <= '{en: port_en, rd: rd_wr_n, sclk: sclk, din: sdin};
            en_prev   <= smp.en;
            sclk_prev <= smp.sclk;
        end
    end

    always_comb begin
        ev.en_rise   =  smp.en   & ~en_prev;
        ev.en_fall   = ~smp.en   &  en_prev;
        ev.sclk_rise =  smp.sclk & ~sclk_prev;
        ev.sclk_fall = ~smp.sclk &  sclk_prev;
    end
endmodule

// File: rtl/wport_wr_shift.sv
module wport_wr_shift #(
    parameter int unsigned FRAME = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_q,
    input  logic             rd_q,
    input  logic             din_q,
    input  logic             en_rise,
    input  logic             en_fall,
    input  logic             sclk_rise,
    output logic [FRAME-1:0] frame_data,
    output logic             load_pulse
);
    localparam int unsigned CW = $clog2(FRAME + 1);
    localparam logic [CW-1:0] FULL = CW'(FRAME);

    logic [CW-1:0] bit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_data <= '0;
            bit_cnt    <= '0;
        end else if (en_rise) begin
            bit_cnt <= '0;
        end else if (en_q && !rd_q && sclk_rise) begin
            frame_data <= {frame_data[FRAME-2:0], din_q};
            if (bit_cnt != FULL) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    assign load_pulse = en_fall && (bit_cnt == FULL);
endmodule

// File: rtl/wport_bank.sv
module wport_bank #(
    parameter int unsigned WIPER_W    = 8,
    parameter int unsigned NUM_WIPERS = 4,
    localparam int unsigned FRAME     = WIPER_W * NUM_WIPERS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [FRAME-1:0] frame_data,
    output logic [FRAME-1:0] wiper_flat,
    output logic [FRAME-1:0] read_image
);
    for (genvar k = 0; k < NUM_WIPERS; k++) begin : g_wiper
        localparam int unsigned TOP = FRAME - 1 - k * WIPER_W;
        logic [WIPER_W-1:0] pos;

        always_ff @(posedge clk) begin
            if (rst) begin
                pos <= '0;
            end else if (load) begin
                pos <= frame_data[TOP -: WIPER_W];
            end
        end

        assign wiper_flat[k*WIPER_W +: WIPER_W] = pos;
        assign read_image[TOP -: WIPER_W]       = pos;
    end
endmodule

// File: rtl/wport_rd_shift.sv
module wport_rd_shift #(
    parameter int unsigned FRAME = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_q,
    input  logic             rd_q,
    input  logic             en_rise,
    input  logic             en_fall,
    input  logic             sclk_fall,
    input  logic [FRAME-1:0] read_image,
    output logic             rd_bit
);
    logic [FRAME-1:0] rshift;

    always_ff @(posedge clk) begin
        if (rst) begin
            rshift <= '0;
            rd_bit <= 1'b0;
        end else if (en_rise) begin
            rshift <= read_image;
            rd_bit <= 1'b0;
        end else if (en_fall) begin
            rd_bit <= 1'b0;
        end else if (en_q && rd_q && sclk_fall) begin
            rd_bit <= rshift[FRAME-1];
            rshift <= {rshift[FRAME-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/wiper_serial_port.sv
module wiper_serial_port
    import wiper_port_pkg::*;
#(
    parameter int unsigned WIPER_W    = DEF_WIPER_W,
    parameter int unsigned NUM_WIPERS = DEF_NUM_WIPERS,
    localparam int unsigned FRAME     = frame_len(WIPER_W, NUM_WIPERS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_en,
    input  logic             rd_wr_n,
    input  logic             sclk,
    input  logic             sdin,
    output logic             cascade_out,
    output logic [FRAME-1:0] wiper_pos
);
    port_sample_t     smp;
    port_event_t      ev;
    logic [FRAME-1:0] frame_data;
    logic [FRAME-1:0] read_image;
    logic             load_pulse;
    logic             rd_bit;

    wport_sampler u_sampler (
        .clk     (clk),
        .rst     (rst),
        .port_en (port_en),
        .rd_wr_n (rd_wr_n),
        .sclk    (sclk),
        .sdin    (sdin),
        .smp     (smp),
        .ev      (ev)
    );

    wport_wr_shift #(.FRAME(FRAME)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .en_q       (smp.en),
        .rd_q       (smp.rd),
        .din_q      (smp.din),
        .en_rise    (ev.en_rise),
        .en_fall    (ev.en_fall),
        .sclk_rise  (ev.sclk_rise),
        .frame_data (frame_data),
        .load_pulse (load_pulse)
    );

    wport_bank #(.WIPER_W(WIPER_W), .NUM_WIPERS(NUM_WIPERS)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .load       (load_pulse),
        .frame_data (frame_data),
        .wiper_flat (wiper_pos),
        .read_image (read_image)
    );

    wport_rd_shift #(.FRAME(FRAME)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .en_q       (smp.en),
        .rd_q       (smp.rd),
        .en_rise    (ev.en_rise),
        .en_fall    (ev.en_fall),
        .sclk_fall  (ev.sclk_fall),
        .read_image (read_image),
        .rd_bit     (rd_bit)
    );

    // cascade output: pass-through, inhibit, or readback bit
    always_comb begin
        if (!port_en) begin
            cascade_out = sdin;
        end else if (!rd_wr_n) begin
            cascade_out = 1'b0;
        end else begin
            cascade_out = rd_bit;
        end
    end
endmodule

// File: rtl/wport_checker.sv
module wport_checker #(
    parameter int unsigned FRAME = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             port_en,
    input logic             rd_wr_n,
    input logic             sdin,
    input logic             cascade_out,
    input logic [FRAME-1:0] wiper_pos,
    input logic             load_pulse,
    input logic             rd_bit,
    input logic             sclk_fall,
    input logic             en_edge
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wiper_pos == '0));

    assert_passthru_R2: assert property (@(posedge clk) disable iff (rst)
        !port_en |-> (cascade_out == sdin));

    assert_inhibit_R3: assert property (@(posedge clk) disable iff (rst)
        (port_en && !rd_wr_n) |-> !cascade_out);

    // R6 / R10: registers move only on a committed full frame
    assert_load_only_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(wiper_pos) |-> $past(load_pulse));

    assert_read_step_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_bit) |-> $past(sclk_fall || en_edge));
endmodule

bind wiper_serial_port wport_checker #(.FRAME(FRAME)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .port_en     (port_en),
    .rd_wr_n     (rd_wr_n),
    .sdin        (sdin),
    .cascade_out (cascade_out),
    .wiper_pos   (wiper_pos),
    .load_pulse  (load_pulse),
    .rd_bit      (rd_bit),
    .sclk_fall   (ev.sclk_fall),
    .en_edge     (ev.en_rise || ev.en_fall)
);

// File: tb/tb_wiper_serial_port.sv
module tb_wiper_serial_port;
    localparam int PH    = 4;
    localparam int FRAME = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic port_en = 1'b0;
    logic rd_wr_n = 1'b0;
    logic sclk = 1'b0;
    logic sdin = 1'b0;
    logic cascade_out;
    logic [FRAME-1:0] wiper_pos;

    int checks = 0;
    int errors = 0;
    logic [FRAME-1:0] exp_img = '0;

    always #10 clk = ~clk;

    wiper_serial_port dut (
        .clk(clk), .rst(rst), .port_en(port_en), .rd_wr_n(rd_wr_n),
        .sclk(sclk), .sdin(sdin), .cascade_out(cascade_out), .wiper_pos(wiper_pos)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_wiper(input logic [FRAME-1:0] img, input int k);
        return img[FRAME-1-8*k -: 8];
    endfunction

    task automatic check_wipers(input string req);
        for (int k = 0; k < 4; k++)
            check(req, 64'(wiper_pos[k*8 +: 8]), 64'(exp_wiper(exp_img, k)));
    endtask

    task automatic send_bit(input logic b);
        sdin = b;
        wait_cyc(PH);
        sclk = 1'b1;
        wait_cyc(PH);
        sclk = 1'b0;
    endtask

    // write session of n bits, s[n-1] first
    task automatic write_frame(input logic [63:0] s, input int n, input logic inh_chk);
        rd_wr_n = 1'b0;
        port_en = 1'b1;
        wait_cyc(PH);
        for (int i = n - 1; i >= 0; i--) begin
            send_bit(s[i]);
            if (inh_chk && s[i]) check("R3 inhibit", 64'(cascade_out), 64'd0);
        end
        wait_cyc(PH);
        port_en = 1'b0;
        wait_cyc(PH);
        if (n >= FRAME) exp_img = s[FRAME-1:0];
    endtask

    task automatic read_bit(input string req, input logic exp);
        sclk = 1'b1;
        wait_cyc(PH);
        sclk = 1'b0;
        wait_cyc(PH);
        check(req, 64'(cascade_out), 64'(exp));
    endtask

    task automatic read_frame(input int n, input int extra);
        rd_wr_n = 1'b1;
        port_en = 1'b1;
        wait_cyc(PH);
        check("R8 low before first fall", 64'(cascade_out), 64'd0);
        for (int i = 0; i < n; i++) read_bit("R7 readback order", exp_img[FRAME-1-i]);
        for (int i = 0; i < extra; i++) read_bit("R9 zero after frame", 1'b0);
        port_en = 1'b0;
        wait_cyc(PH);
        check_wipers("R10 read leaves wipers");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [63:0] s;
        int n;
        void'($urandom(32'd2718));
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);
        check_wipers("R1 reset zero");

        // R2 pass-through, combinational
        for (int i = 0; i < 4; i++) begin
            sdin = i[0];
            #1;
            check("R2 pass-through", 64'(cascade_out), 64'(sdin));
            wait_cyc(1);
        end

        // R4 exact frame, distinct bytes
        write_frame(64'h0000_0000_A1B2_C3D4, FRAME, 1'b1);
        check_wipers("R4 exact frame load");
        read_frame(FRAME, 3);

        // R5 over-long frame
        write_frame(64'h0000_00FF_1234_5678, 40, 1'b0);
        check_wipers("R5 last 32 bits");

        // R6 short frame (31 bits)
        write_frame(64'h0000_0000_7FFF_FFFF, 31, 1'b0);
        check_wipers("R6 short frame ignored");

        // R8 restart after partial read
        rd_wr_n = 1'b1;
        port_en = 1'b1;
        wait_cyc(PH);
        for (int i = 0; i < 5; i++) read_bit("R7 partial read", exp_img[FRAME-1-i]);
        port_en = 1'b0;
        wait_cyc(PH);
        read_frame(8, 0);

        // random frames
        for (int it = 0; it < 20; it++) begin
            s = {$urandom, $urandom};
            case ($urandom_range(2))
                0: n = FRAME;
                1: n = FRAME + int'($urandom_range(1, 16));
                default: n = FRAME - int'($urandom_range(1, 8));
            endcase
            write_frame(s, n, 1'b0);
            check_wipers(n > FRAME ? "R5 random long" : (n == FRAME ? "R4 random" : "R6 random short"));
            read_frame(FRAME, 1);
        end

        // reset returns to zero
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        exp_img = '0;
        wait_cyc(1);
        check_wipers("R1 reset again");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule